// File: doc/BRIEF.md
# PWM Output Action Qualifier with Continuous Software Force

This block decides the level of the two pins of a two-channel pulse-width modulator. A separate time-base block supplies a tick strobe, the counter value, its counting direction and strobes that mark counter zero and the period match. The qualifier compares the counter with two 16-bit compare values, A and B. On each tick it turns the events that occurred into a drive-low, drive-high or toggle action, one per channel, as a per-channel action word directs.

A continuous software force can override either pin. Writes go to a shadow copy. The shadow becomes the active force at a reload point that is itself selectable: counter zero, period match, either of the two, or the next tick. While a channel's active force says low or high, every event action for that channel is ignored. In the usual setup the period match drives the pin high and the up-count compare drives it low (channel 0 on compare A, channel 1 on compare B). Swapping those two codes inverts the polarity.

Top module: `pwm_action_qual`

## Requirements
- R1: While reset is held and after it is released, both pins are low and the force shadow and active values are 00, meaning no force.
- R2: A pin changes only at a clock edge where `tb_tick` is high. Between ticks it holds its level.
- R3: Each action word holds 2-bit codes: zero event at bits 1:0, period event at bits 3:2, compare A while counting up at bits 5:4, and compare B while counting up at bits 9:8. Code 00 means no action, 01 drive low, 10 drive high and 11 toggle. Bits 7:6 and 11:10 have no effect.
- R4: A compare event occurs only on a tick where `tb_cnt_up` is high and `tb_cnt` equals that compare value. A match while counting down has no effect.
- R5: When several events with non-00 codes fall on one tick, compare B wins over compare A, compare A over period, and period over zero. An event whose code is 00 does not block a lower-priority event.
- R6: Force field bits 1:0 belong to channel 0 and bits 3:2 to channel 1. 01 forces low, 10 forces high, and 00 or 11 means no force. An active force sets the pin at every tick and overrides all event actions.
- R7: Reload select 00 copies the shadow into the active force on a tick with the zero strobe, 01 on a tick with the period strobe, and 10 on a tick with either strobe. At that same tick the pin already follows the newly loaded value.
- R8: Reload select 11 copies the shadow on every tick. A force written in one cycle takes effect at the first tick in a later cycle.
- R9: With period code 10 and the compare code 01, a pin is high from the period tick up to the matching up-count compare tick and low afterwards. With the codes swapped, the waveform is inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | Time-base tick; qualifies all events |
| tb_cnt | input | CNT_W | Time-base counter value |
| tb_cnt_up | input | 1 | High while the counter counts up |
| tb_zero | input | 1 | Counter-at-zero strobe |
| tb_period | input | 1 | Counter-at-period strobe |
| cmp_a_val | input | CNT_W | Compare value A |
| cmp_b_val | input | CNT_W | Compare value B |
| act_cfg_0 | input | 12 | Action word for channel 0 |
| act_cfg_1 | input | 12 | Action word for channel 1 |
| frc_wr | input | 1 | Write strobe for the force shadow |
| frc_data | input | 4 | New force shadow value |
| frc_reload | input | 2 | Reload point for the force shadow |
| pwm_out | output | 2 | PWM pins, channel 0 at bit 0 |

## Verification
Two things can land on the same tick: a force reload and an event action on one pin, and also several events on one pin, such as zero together with compare A or period together with compare B. The bench sets compare values equal to 0 and to the period, and writes the force shadow both on and off reload ticks in every reload mode, with slow and fast tick rates. On every clock a behavioural model that applies the events from lowest to highest priority and loads the force before acting gives the expected pin levels. The pins are compared with that model.

// File: rtl/pwmaq_pkg.sv
package pwmaq_pkg;
  localparam int NCH       = 2;
  localparam int NCMP      = 2;
  localparam int FLD_W     = 2;
  localparam int ACT_CFG_W = 12;
  localparam int FRC_W     = NCH * FLD_W;

  // field positions inside a channel action word
  localparam int ZRO_LSB = 0;
  localparam int PRD_LSB = 2;
  localparam int CA_LSB  = 4;
  localparam int CB_LSB  = 8;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } act_code_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'b00,
    RLD_PERIOD = 2'b01,
    RLD_EITHER = 2'b10,
    RLD_NOW    = 2'b11
  } reload_e;

  // tick-qualified events
  typedef struct packed {
    logic cb;
    logic ca;
    logic prd;
    logic zro;
  } evt_s;

  function automatic logic [FLD_W-1:0] get_field(
    input logic [ACT_CFG_W-1:0] cfg, input int lsb);
    return cfg[lsb +: FLD_W];
  endfunction

  // highest-priority event with a non-zero code wins
  function automatic logic [FLD_W-1:0] resolve_action(
    input evt_s ev, input logic [ACT_CFG_W-1:0] cfg);
    logic [FLD_W-1:0] zc, pc, ac, bc;
    zc = get_field(cfg, ZRO_LSB);
    pc = get_field(cfg, PRD_LSB);
    ac = get_field(cfg, CA_LSB);
    bc = get_field(cfg, CB_LSB);
    if (ev.cb && bc != ACT_NONE)       return bc;
    else if (ev.ca && ac != ACT_NONE)  return ac;
    else if (ev.prd && pc != ACT_NONE) return pc;
    else if (ev.zro && zc != ACT_NONE) return zc;
    else                               return ACT_NONE;
  endfunction

  function automatic logic apply_action(input logic cur,
                                        input logic [FLD_W-1:0] code);
    logic r;
    case (code)
      ACT_LOW:    r = 1'b0;
      ACT_HIGH:   r = 1'b1;
      ACT_TOGGLE: r = ~cur;
      default:    r = cur;
    endcase
    return r;
  endfunction

  function automatic logic force_on(input logic [FLD_W-1:0] code);
    return (code == ACT_LOW) || (code == ACT_HIGH);
  endfunction

  function automatic logic reload_due(input logic [1:0] sel, input evt_s ev,
                                      input logic tick);
    logic r;
    case (sel)
      RLD_ZERO:   r = ev.zro;
      RLD_PERIOD: r = ev.prd;
      RLD_EITHER: r = ev.zro | ev.prd;
      default:    r = tick;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pwmaq_event_det.sv
module pwmaq_event_det
  import pwmaq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                       tick,
  input  logic [CNT_W-1:0]           cnt,
  input  logic                       cnt_up,
  input  logic                       zero_in,
  input  logic                       period_in,
  input  logic [NCMP-1:0][CNT_W-1:0] cmp_vals,
  output evt_s                       ev
);
  logic [NCMP-1:0] match;

  generate
    for (genvar i = 0; i < NCMP; i++) begin : g_cmp
      assign match[i] = tick & cnt_up & (cnt == cmp_vals[i]);
    end
  endgenerate

  always_comb begin
    ev.zro = tick & zero_in;
    ev.prd = tick & period_in;
    ev.ca  = match[0];
    ev.cb  = match[1];
  end
endmodule

// File: rtl/pwmaq_force_ctl.sv
module pwmaq_force_ctl
  import pwmaq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  evt_s             ev,
  input  logic             wr,
  input  logic [FRC_W-1:0] wdata,
  input  logic [1:0]       reload_sel,
  output logic [FRC_W-1:0] shadow,
  output logic [FRC_W-1:0] active,
  output logic [FRC_W-1:0] eff,
  output logic             load
);
  logic [FRC_W-1:0] shadow_q, active_q;

  assign load = tick & reload_due(reload_sel, ev, tick);
  assign eff  = load ? shadow_q : active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
    end else begin
      if (wr)   shadow_q <= wdata;
      if (load) active_q <= shadow_q;
    end
  end

  assign shadow = shadow_q;
  assign active = active_q;
endmodule

// File: rtl/pwmaq_channel.sv
module pwmaq_channel
  import pwmaq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  evt_s                 ev,
  input  logic [ACT_CFG_W-1:0] cfg,
  input  logic [FLD_W-1:0]     force_code,
  output logic                 pin
);
  logic pin_q, pin_d;
  logic [FLD_W-1:0] act;

  assign act = resolve_action(ev, cfg);

  always_comb begin
    if (force_on(force_code)) pin_d = (force_code == ACT_HIGH);
    else                      pin_d = apply_action(pin_q, act);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pin_q <= 1'b0;
    else if (tick) pin_q <= pin_d;
  end

  assign pin = pin_q;
endmodule

// File: rtl/pwm_action_qual.sv
module pwm_action_qual
  import pwmaq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tb_tick,
  input  logic [CNT_W-1:0]     tb_cnt,
  input  logic                 tb_cnt_up,
  input  logic                 tb_zero,
  input  logic                 tb_period,
  input  logic [CNT_W-1:0]     cmp_a_val,
  input  logic [CNT_W-1:0]     cmp_b_val,
  input  logic [ACT_CFG_W-1:0] act_cfg_0,
  input  logic [ACT_CFG_W-1:0] act_cfg_1,
  input  logic                 frc_wr,
  input  logic [FRC_W-1:0]     frc_data,
  input  logic [1:0]           frc_reload,
  output logic [NCH-1:0]       pwm_out
);
  evt_s                           ev;
  logic [FRC_W-1:0]               frc_shadow, frc_active, eff_force;
  logic                           frc_load;
  logic [NCMP-1:0][CNT_W-1:0]     cmp_vals;
  logic [NCH-1:0][ACT_CFG_W-1:0]  cfg_vec;

  assign cmp_vals = {cmp_b_val, cmp_a_val};
  assign cfg_vec  = {act_cfg_1, act_cfg_0};

  pwmaq_event_det #(.CNT_W(CNT_W)) u_evt (
    .tick      (tb_tick),
    .cnt       (tb_cnt),
    .cnt_up    (tb_cnt_up),
    .zero_in   (tb_zero),
    .period_in (tb_period),
    .cmp_vals  (cmp_vals),
    .ev        (ev)
  );

  pwmaq_force_ctl u_frc (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tb_tick),
    .ev         (ev),
    .wr         (frc_wr),
    .wdata      (frc_data),
    .reload_sel (frc_reload),
    .shadow     (frc_shadow),
    .active     (frc_active),
    .eff        (eff_force),
    .load       (frc_load)
  );

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      pwmaq_channel u_ch (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tb_tick),
        .ev         (ev),
        .cfg        (cfg_vec[c]),
        .force_code (eff_force[c*FLD_W +: FLD_W]),
        .pin        (pwm_out[c])
      );
    end
  endgenerate
endmodule

// File: rtl/pwmaq_checker.sv
module pwmaq_checker
  import pwmaq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             zero_in,
  input logic             cnt_up,
  input logic [1:0]       reload_sel,
  input logic [NCH-1:0]   pins,
  input evt_s             ev,
  input logic [FRC_W-1:0] eff_force,
  input logic [FRC_W-1:0] frc_active,
  input logic [FRC_W-1:0] frc_shadow,
  input logic             frc_load
);
  AST_HOLD_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(pins)); // R2

  AST_CMP_UP_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.ca || ev.cb) |-> (tick && cnt_up)); // R4

  AST_FORCE0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && eff_force[1:0] == 2'b01) |=> !pins[0]); // R6

  AST_FORCE1_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && eff_force[3:2] == 2'b10) |=> pins[1]); // R6

  AST_NOW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload_sel == 2'b11) |=> (frc_active == $past(frc_shadow))); // R8

  AST_ZERO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_sel == 2'b00 && !(tick && zero_in)) |=> $stable(frc_active)); // R7

  AST_LOAD_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    frc_load |-> tick); // R7
endmodule

bind pwm_action_qual pwmaq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tb_tick),
  .zero_in    (tb_zero),
  .cnt_up     (tb_cnt_up),
  .reload_sel (frc_reload),
  .pins       (pwm_out),
  .ev         (ev),
  .eff_force  (eff_force),
  .frc_active (frc_active),
  .frc_shadow (frc_shadow),
  .frc_load   (frc_load)
);

// File: tb/pwm_action_qual_tb.sv
module pwm_action_qual_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick;
  logic [15:0] cnt;
  logic        cnt_up;
  logic        zero;
  logic        period;
  logic [15:0] cmpa, cmpb;
  logic [11:0] cfg0, cfg1;
  logic        frc_wr;
  logic [3:0]  frc_data;
  logic [1:0]  frc_reload;
  logic [1:0]  pwm_out;

  always #10 clk = ~clk;

  pwm_action_qual u_dut (
    .clk(clk), .rst_n(rst_n), .tb_tick(tick), .tb_cnt(cnt), .tb_cnt_up(cnt_up),
    .tb_zero(zero), .tb_period(period), .cmp_a_val(cmpa), .cmp_b_val(cmpb),
    .act_cfg_0(cfg0), .act_cfg_1(cfg1), .frc_wr(frc_wr), .frc_data(frc_data),
    .frc_reload(frc_reload), .pwm_out(pwm_out)
  );

  int    total = 0, bad = 0;
  bit    done = 0;
  string phase = "R1";

  // time-base stimulus state
  int  prd = 9, tdiv = 1, cyc = 0;
  bit  updown = 0, dir = 1;
  int  c = 0;
  bit  pend_wr = 0;
  logic [3:0] pend_data = 0;

  // behavioural reference
  logic [1:0]  m_out;
  logic [3:0]  m_sh, m_act;
  logic        ld;
  logic [1:0]  f, code;
  logic [11:0] cf;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_out = 0; m_sh = 0; m_act = 0;
    end else begin
      if (tick) begin
        case (frc_reload)
          2'd0: ld = zero;
          2'd1: ld = period;
          2'd2: ld = zero || period;
          default: ld = 1'b1;
        endcase
        if (ld) m_act = m_sh;
        for (int ch = 0; ch < 2; ch++) begin
          f  = m_act[2*ch +: 2];
          cf = (ch == 1) ? cfg1 : cfg0;
          if (f == 2'b01) m_out[ch] = 1'b0;
          else if (f == 2'b10) m_out[ch] = 1'b1;
          else begin
            code = 0;
            if (zero && cf[1:0] != 0) code = cf[1:0];
            if (period && cf[3:2] != 0) code = cf[3:2];
            if (cnt_up && cnt == cmpa && cf[5:4] != 0) code = cf[5:4];
            if (cnt_up && cnt == cmpb && cf[9:8] != 0) code = cf[9:8];
            if (code == 2'b01) m_out[ch] = 1'b0;
            else if (code == 2'b10) m_out[ch] = 1'b1;
            else if (code == 2'b11) m_out[ch] = ~m_out[ch];
          end
        end
      end
      if (frc_wr) m_sh = frc_data;
    end
  end

  task automatic drive_tb();
    tick   = ((cyc % tdiv) == 0);
    cnt    = 16'(c);
    cnt_up = updown ? dir : 1'b1;
    zero   = (c == 0);
    period = (c == prd);
    frc_wr = pend_wr;
    if (pend_wr) frc_data = pend_data;
    pend_wr = 0;
  endtask

  task automatic step();
    @(negedge clk);
    total++;
    if (pwm_out !== m_out) begin
      bad++;
      $display("FAIL %s: pwm_out=%b expected=%b at cycle %0d", phase, pwm_out, m_out, cyc);
    end
    if (tick) begin
      if (!updown) c = (c >= prd) ? 0 : c + 1;
      else if (dir) begin c = c + 1; if (c >= prd) begin c = prd; dir = 0; end end
      else begin c = c - 1; if (c <= 0) begin c = 0; dir = 1; end end
    end
    cyc++;
    drive_tb();
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr_force(logic [3:0] d);
    pend_wr = 1; pend_data = d;
    step();
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    finish_up();
  end

  initial begin
    rst_n = 0; cmpa = 3; cmpb = 6; cfg0 = 0; cfg1 = 0;
    frc_data = 0; frc_reload = 2'd0; frc_wr = 0;
    drive_tb();
    repeat (3) @(negedge clk);
    total++;
    if (pwm_out !== 2'b00) begin
      bad++; $display("FAIL R1: pwm_out=%b expected=00 in reset", pwm_out);
    end
    rst_n = 1;
    phase = "R1 after reset"; run(2);

    phase = "R9 normal polarity";
    cfg0 = (12'd2 << 2) | (12'd1 << 4);
    cfg1 = (12'd2 << 2) | (12'd1 << 8);
    run(60);
    phase = "R9 inverted polarity";
    cfg0 = (12'd1 << 2) | (12'd2 << 4);
    cfg1 = (12'd1 << 2) | (12'd2 << 8);
    run(40);

    phase = "R2 slow tick";
    tdiv = 3; run(90);

    phase = "R3 toggle and unused bits";
    tdiv = 2;
    cfg0 = 12'd3 | 12'hCC0;
    cfg1 = (12'd3 << 2) | 12'hCC0;
    run(60);

    phase = "R4 up-down compare";
    tdiv = 1; updown = 1;
    cfg0 = 12'd1 | (12'd2 << 4);
    cfg1 = 12'd3 << 8;
    run(80);

    phase = "R5 zero vs compare A, period vs compare B";
    updown = 0; cmpa = 0; cmpb = 9;
    cfg0 = 12'd2 | (12'd1 << 4);
    cfg1 = (12'd2 << 2) | (12'd1 << 8);
    run(50);
    phase = "R5 A and B together";
    cmpa = 5; cmpb = 5;
    cfg0 = (12'd2 << 4) | (12'd1 << 8);
    cfg1 = (12'd1 << 4) | (12'd3 << 2);
    run(50);
    phase = "R5 zero code does not block";
    cfg0 = (12'd3 << 4) | (12'd2 << 2);
    cfg1 = (12'd2 << 0) | (12'd0 << 8);
    cmpb = 0;
    run(50);

    phase = "R6 immediate force codes";
    cmpa = 3; cmpb = 6;
    cfg0 = (12'd2 << 2) | (12'd1 << 4);
    cfg1 = (12'd2 << 2) | (12'd1 << 8);
    frc_reload = 2'd3;
    wr_force(4'b1001); run(30);
    wr_force(4'b0110); run(30);
    wr_force(4'b1111); run(30);
    wr_force(4'b0000); run(20);

    phase = "R8 immediate with slow tick";
    tdiv = 4;
    for (int k = 0; k < 8; k++) begin
      wr_force(k[0] ? 4'b0101 : 4'b1010);
      run(k + 2);
    end
    wr_force(4'b0000); run(20);

    phase = "R7 shadow reload modes";
    for (int mode = 0; mode < 3; mode++) begin
      frc_reload = 2'(mode);
      for (int t = 1; t <= 2; t++) begin
        tdiv = t;
        run(3);
        wr_force(4'b0101); run(25);
        wr_force(4'b1010); run(13);
        wr_force(4'b0000); run(30);
      end
    end

    phase = "R1 reset mid-run";
    wr_force(4'b1010); run(5);
    rst_n = 0; run(3); rst_n = 1;
    frc_reload = 2'd0; run(30);

    finish_up();
  end
endmodule